// File: doc/BRIEF.md
# SDRAM Calibration-Register Read Path

This block models the device side of a DDR3-class memory when its multi-purpose register is switched into readout mode. It watches the decoded command pins (chip select, row strobe, column strobe, write enable) together with the address and bank inputs. It also watches a shadow of the mode-register fields that select register readout, the register location and the burst setting. When readout mode is on and a READ arrives, the block replays a fixed calibration pattern on a 16-bit data bus. The pattern starts after the programmed read latency and follows the beat order that the address selects.

Each burst is presented as a stream of beats, one per clock, qualified by `dq_valid`. The bus has no ready signal. A memory device cannot stall its read data, so there is no back-pressure. The receiver must take every beat in the cycle it is valid. A READ whose first beat falls while an earlier burst is still running replaces that burst from that cycle on. Controllers space reads by at least the burst length. NOP, Deselect and all other commands leave a running burst alone.

Top module: `mpr_readout`

## Requirements
- R1: A READ is decoded when `cs_n`=0, `ras_n`=1, `cas_n`=0 and `we_n`=1. When it is accepted, `dq_valid` rises exactly `read_lat` cycles after the clock edge that sampled the command. The usable range of `read_lat` is 1 to 15, and a value of 0 acts as 1.
- R2: The calibration pattern holds bit value p mod 2 at burst position p, giving 0,1,0,1,0,1,0,1. `dq_beat` shows the burst position of the current beat.
- R3: With `burst_cfg`=00, every burst is 8 beats at positions 0 to 7 in order, whatever A2 is.
- R4: With `burst_cfg`=10, every burst is 4 beats. A2=0 gives positions 0,1,2,3, and A2=1 gives positions 4,5,6,7.
- R5: With `burst_cfg`=01, the burst length is chosen per command: A12=1 gives 8 beats and A12=0 gives 4 beats. A setting of 11 behaves as 00.
- R6: Bit 0 of each byte lane carries the beat's bit. With `lane_fill`=1, bits 7:1 of each lane repeat bit 0. With `lane_fill`=0, bits 7:1 are 0.
- R7: The bank address, A[9:3], A10 and A11 have no effect on the burst.
- R8: A READ with `mpr_loc`≠00 or A[1:0]≠00 still produces its burst, but all data bits are 0. `rd_err` is high for the one cycle after the command edge.
- R9: A READ while `dll_locked`=0 produces no burst. `rd_err` is high for the one cycle after the command edge.
- R10: NOP, Deselect (`cs_n`=1, whatever the other pins are) and non-READ commands neither start nor disturb a burst. A READ while `mpr_on`=0 produces no burst and no error.
- R11: While `dq_valid` is low, `dq` and `dq_beat` are 0. Reset leaves the bus idle with `rd_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command and data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Command address A[12:0] |
| ba | input | 3 | Bank address (ignored) |
| mpr_on | input | 1 | Register readout mode enable |
| mpr_loc | input | 2 | Register location, 00 is the calibration pattern |
| burst_cfg | input | 2 | 00 fixed 8, 01 per-command via A12, 10 fixed 4 |
| read_lat | input | 4 | Read latency in cycles |
| lane_fill | input | 1 | 1 repeats bit 0 across each lane, 0 zeros bits 7:1 |
| dll_locked | input | 1 | Clock alignment locked |
| dq | output | 16 | Data beat |
| dq_valid | output | 1 | Beat valid |
| dq_beat | output | 3 | Burst position of the current beat |
| rd_err | output | 1 | One-cycle flag for a rejected or malformed READ |

## Verification
The bench targets the upper-half 4-beat chop, which a design with the A2 decode wrong would deliver as positions 0 to 3. It also targets per-command chop through A12, where an inverted polarity swaps 4- and 8-beat bursts. Latency is checked at 0, 1 and 15, where an off-by-one in the delay line shifts the first beat or loses it. Error reads must still stream zeros, and unlocked reads must not stream at all. A Deselect that carries READ pin levels, or a write issued mid-burst, would start or cut a burst in a decoder that ignored chip select or the command type.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_READ  = 2'd2,
    CMD_OTHER = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    BURST_FIX8 = 2'b00,
    BURST_OTF  = 2'b01,
    BURST_FIX4 = 2'b10,
    BURST_RSV  = 2'b11
  } burst_cfg_e;

  typedef struct packed {
    logic valid;
    logic chop;
    logic upper;
    logic zero;
  } beat_req_t;
endpackage

// File: rtl/mpr_cmd_decode.sv
module mpr_cmd_decode
  import mpr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n)                          cmd = CMD_DESEL;
    else if (ras_n && cas_n && we_n)   cmd = CMD_NOP;
    else if (ras_n && !cas_n && we_n)  cmd = CMD_READ;
    else                               cmd = CMD_OTHER;
  end
endmodule

// File: rtl/mpr_lat_pipe.sv
module mpr_lat_pipe
  import mpr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LAT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  beat_req_t        ins,
  input  logic [LAT_W-1:0] lat,
  output beat_req_t        head
);
  beat_req_t stage [DEPTH];
  beat_req_t nxt   [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_shift
      if (g == DEPTH - 1) begin : g_top
        assign nxt[g] = '0;
      end else begin : g_mid
        assign nxt[g] = stage[g+1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins.valid && (i == int'(lat) - 1)) stage[i] <= ins;
        else                                   stage[i] <= nxt[i];
      end
    end
  end

  assign head = stage[0];

  // R1
  lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins.valid && lat == LAT_W'(1)) |=> head.valid);
endmodule

// File: rtl/mpr_burst_gen.sv
module mpr_burst_gen
  import mpr_pkg::*;
#(
  parameter int          LANE_W    = 8,
  parameter int          NUM_LANES = 2,
  parameter logic [7:0]  PATTERN   = 8'b1010_1010,
  localparam int         DQ_W      = LANE_W * NUM_LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  beat_req_t       head,
  input  logic            lane_fill,
  output logic [DQ_W-1:0] dq,
  output logic            dq_valid,
  output logic [2:0]      dq_beat
);
  logic       busy;
  logic [2:0] pos, last_pos;
  logic       zero_q;
  logic       beat_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pos      <= '0;
      last_pos <= '0;
      zero_q   <= 1'b0;
    end else if (head.valid) begin
      busy     <= 1'b1;
      pos      <= head.upper ? 3'd4 : 3'd0;
      last_pos <= (head.chop && !head.upper) ? 3'd3 : 3'd7;
      zero_q   <= head.zero;
    end else if (busy) begin
      if (pos == last_pos) begin
        busy <= 1'b0;
        pos  <= '0;
      end else begin
        pos  <= pos + 3'd1;
      end
    end
  end

  assign beat_bit = busy && !zero_q && PATTERN[pos];
  assign dq_valid = busy;
  assign dq_beat  = busy ? pos : 3'd0;

  genvar l;
  generate
    for (l = 0; l < NUM_LANES; l++) begin : g_lane
      assign dq[l*LANE_W +: LANE_W] = lane_fill ? {LANE_W{beat_bit}}
                                                : {{(LANE_W-1){1'b0}}, beat_bit};
    end
  endgenerate

  // R4
  start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (pos == 3'd0 || pos == 3'd4));

  // R3
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pos == 3'd7 && !head.valid) |=> !busy);
endmodule

// File: rtl/mpr_readout.sv
module mpr_readout
  import mpr_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 3,
  parameter int LANE_W    = 8,
  parameter int DQ_W      = 16,
  parameter int LAT_DEPTH = 16,
  parameter int CHOP_BIT  = 12,
  parameter int ORDER_BIT = 2,
  localparam int NUM_LANES = DQ_W / LANE_W,
  localparam int LAT_W     = $clog2(LAT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   ba,
  input  logic              mpr_on,
  input  logic [1:0]        mpr_loc,
  input  logic [1:0]        burst_cfg,
  input  logic [LAT_W-1:0]  read_lat,
  input  logic              lane_fill,
  input  logic              dll_locked,
  output logic [DQ_W-1:0]   dq,
  output logic              dq_valid,
  output logic [2:0]        dq_beat,
  output logic              rd_err
);
  localparam logic [DQ_W-1:0] LSB_MASK = {NUM_LANES{{(LANE_W-1){1'b0}}, 1'b1}};

  cmd_e       cmd;
  logic       mpr_read, bad_addr, chop;
  logic [LAT_W-1:0] eff_lat;
  beat_req_t  req, head;
  logic       unused_bits;

  assign unused_bits = ^{ba, addr[ADDR_W-2:ORDER_BIT+1]};

  mpr_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
  );

  assign mpr_read = (cmd == CMD_READ) && mpr_on;
  assign bad_addr = (mpr_loc != 2'b00) || (addr[1:0] != 2'b00);
  assign eff_lat  = (read_lat == '0) ? LAT_W'(1) : read_lat;

  always_comb begin
    case (burst_cfg)
      BURST_FIX4: chop = 1'b1;
      BURST_OTF:  chop = !addr[CHOP_BIT];
      default:    chop = 1'b0;
    endcase
  end

  always_comb begin
    req.valid = mpr_read && dll_locked;
    req.chop  = chop;
    req.upper = chop && addr[ORDER_BIT];
    req.zero  = bad_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_err <= 1'b0;
    else        rd_err <= mpr_read && (!dll_locked || bad_addr);
  end

  mpr_lat_pipe #(.DEPTH(LAT_DEPTH), .LAT_W(LAT_W)) u_pipe (
    .clk (clk), .rst_n (rst_n), .ins (req), .lat (eff_lat), .head (head)
  );

  mpr_burst_gen #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_burst (
    .clk (clk), .rst_n (rst_n), .head (head), .lane_fill (lane_fill),
    .dq (dq), .dq_valid (dq_valid), .dq_beat (dq_beat)
  );

  // R6
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && !lane_fill) |-> ((dq & ~LSB_MASK) == '0));

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid |-> (dq == '0 && dq_beat == 3'd0));

  // R9
  dll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_READ) && mpr_on && !dll_locked) |=> rd_err);

  // R10
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !req.valid);
endmodule

// File: tb/mpr_readout_test.sv
module mpr_readout_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cs_n, ras_n, cas_n, we_n;
  logic [12:0] addr;
  logic [2:0]  ba;
  logic        mpr_on, lane_fill, dll_locked;
  logic [1:0]  mpr_loc, burst_cfg;
  logic [3:0]  read_lat;
  logic [15:0] dq;
  logic        dq_valid, rd_err;
  logic [2:0]  dq_beat;

  mpr_readout uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .mpr_on(mpr_on), .mpr_loc(mpr_loc),
    .burst_cfg(burst_cfg), .read_lat(read_lat), .lane_fill(lane_fill),
    .dll_locked(dll_locked), .dq(dq), .dq_valid(dq_valid), .dq_beat(dq_beat),
    .rd_err(rd_err)
  );

  localparam int SLOTS = 4096;
  int    exp_v [SLOTS];
  int    exp_p [SLOTS];
  int    exp_z [SLOTS];
  int    exp_e [SLOTS];
  string exp_tag [SLOTS];
  int    edges = 0, checks = 0, fails = 0;
  bit    done = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic compare();
    int i = edges % SLOTS;
    logic       b;
    logic [7:0] lane;
    logic [15:0] edq;
    b    = (exp_v[i] != 0) && (exp_z[i] == 0) && ((exp_p[i] % 2) == 1);
    lane = lane_fill ? {8{b}} : {7'b0, b};
    edq  = {lane, lane};
    checks++;
    if (dq_valid !== (exp_v[i] != 0) || dq_beat !== 3'(exp_v[i] != 0 ? exp_p[i] : 0) ||
        dq !== edq || rd_err !== (exp_e[i] != 0)) begin
      fails++;
      $display("FAIL %s edge %0d: valid/beat/dq/err got %0b/%0d/%h/%0b expected %0b/%0d/%h/%0b",
               exp_tag[i], edges, dq_valid, dq_beat, dq, rd_err,
               exp_v[i] != 0, exp_v[i] != 0 ? exp_p[i] : 0, edq, exp_e[i] != 0);
    end
    exp_v[i] = 0; exp_p[i] = 0; exp_z[i] = 0; exp_e[i] = 0; exp_tag[i] = "R11";
  endtask

  task automatic tick();
    @(posedge clk);
    edges++;
    @(negedge clk);
    compare();
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic drive(input logic c, input logic r, input logic a, input logic w);
    cs_n = c; ras_n = r; cas_n = a; we_n = w;
  endtask

  // Schedules the reference outcome of a READ from the requirements, then issues it.
  task automatic issue_read(input string tag, input logic [12:0] a, input logic [2:0] b);
    int e = edges + 1;
    int l = (read_lat == 0) ? 1 : int'(read_lat);
    bit bad = (mpr_loc != 2'b00) || (a[1:0] != 2'b00);
    for (int k = e; k <= e + l + 9; k++) exp_tag[k % SLOTS] = tag;
    if (mpr_on && (!dll_locked || bad)) exp_e[e % SLOTS] = 1;
    if (mpr_on && dll_locked) begin
      int n = (burst_cfg == 2'b10 || (burst_cfg == 2'b01 && !a[12])) ? 4 : 8;
      int s = (n == 4 && a[2]) ? 4 : 0;
      for (int j = 0; j < n; j++) begin
        exp_v[(e + l + j) % SLOTS] = 1;
        exp_p[(e + l + j) % SLOTS] = s + j;
        exp_z[(e + l + j) % SLOTS] = bad ? 1 : 0;
      end
    end
    addr = a; ba = b;
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    tick();
    drive(1'b0, 1'b1, 1'b1, 1'b1);
    addr = 13'($urandom); ba = 3'($urandom);
  endtask

  function automatic logic [12:0] junk(input logic a12, input logic a2, input logic [1:0] lo);
    logic [12:0] r = 13'($urandom);
    r[12] = a12; r[2] = a2; r[1:0] = lo;
    return r;
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got still running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      exp_v[i] = 0; exp_p[i] = 0; exp_z[i] = 0; exp_e[i] = 0; exp_tag[i] = "R11";
    end
    rst_n = 1'b0; drive(1'b1, 1'b1, 1'b1, 1'b1);
    addr = '0; ba = '0; mpr_on = 1'b1; mpr_loc = 2'b00; burst_cfg = 2'b00;
    read_lat = 4'd5; lane_fill = 1'b1; dll_locked = 1'b1;
    gap(3);                                  // R11 reset state
    rst_n = 1'b1;
    gap(3);

    // R1 R2 R3 R6: 8-beat burst, filled lanes
    issue_read("R3", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(16);
    // R3 R7: A2 and the ignored address/bank bits do not alter an 8-beat burst
    issue_read("R7", junk(1'b0, 1'b1, 2'b00), 3'd5); gap(16);
    issue_read("R7", 13'b0_1111_1111_1000, 3'd7); gap(16);

    // R4 R6: fixed chop, both halves, zeroed upper lane bits
    burst_cfg = 2'b10; lane_fill = 1'b0;
    issue_read("R4", junk(1'b1, 1'b0, 2'b00), 3'd2); gap(16);
    issue_read("R4", junk(1'b1, 1'b1, 2'b00), 3'd1); gap(16);

    // R5: per-command chop via A12, and setting 11 acting as 00
    burst_cfg = 2'b01; lane_fill = 1'b1;
    issue_read("R5", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(16);
    issue_read("R5", junk(1'b0, 1'b1, 2'b00), 3'd0); gap(16);
    issue_read("R5", junk(1'b0, 1'b0, 2'b00), 3'd0); gap(16);
    burst_cfg = 2'b11;
    issue_read("R5", junk(1'b0, 1'b1, 2'b00), 3'd0); gap(16);

    // R1: latency corners
    burst_cfg = 2'b00;
    read_lat = 4'd1;  issue_read("R1", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(14);
    read_lat = 4'd0;  issue_read("R1", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(14);
    read_lat = 4'd15; issue_read("R1", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(28);
    read_lat = 4'd4;

    // R8: reserved location and misaligned low address bits
    mpr_loc = 2'b01; issue_read("R8", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(16);
    mpr_loc = 2'b11; issue_read("R8", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(16);
    mpr_loc = 2'b00; issue_read("R8", junk(1'b1, 1'b0, 2'b10), 3'd0); gap(16);

    // R9: unlocked clock alignment drops the read
    dll_locked = 1'b0; issue_read("R9", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(16);
    dll_locked = 1'b1;

    // R10: readout mode off
    mpr_on = 1'b0; issue_read("R10", junk(1'b1, 1'b0, 2'b00), 3'd0); gap(16);
    mpr_on = 1'b1;

    // R10: Deselect with READ pin levels, a write and NOPs during a burst
    issue_read("R10", junk(1'b1, 1'b0, 2'b00), 3'd0);
    for (int k = 0; k < 12; k++) exp_tag[(edges + 1 + k) % SLOTS] = "R10";
    drive(1'b1, 1'b1, 1'b0, 1'b1); gap(5);
    drive(1'b0, 1'b1, 1'b0, 1'b0); gap(1);
    drive(1'b0, 1'b1, 1'b1, 1'b1); gap(3);
    drive(1'b1, 1'b1, 1'b0, 1'b1); gap(3);
    drive(1'b0, 1'b1, 1'b1, 1'b1); gap(10);

    // R2: back-to-back chops spaced by their length
    burst_cfg = 2'b10;
    issue_read("R2", junk(1'b0, 1'b0, 2'b00), 3'd0); gap(3);
    issue_read("R2", junk(1'b0, 1'b1, 2'b00), 3'd0); gap(16);

    done = 1;
    summary();
    $finish;
  end
endmodule